// File: doc/BRIEF.md
# Serial Quad Wiper Command Controller

This block is the command engine for a four-channel digitally controlled resistor array. It sits on a mode-0 serial slave link made of a serial clock, a data input, a data output with an enable, and an active-low chip select. A host frame begins with one instruction byte. That byte names an operation, one of the four stored register slots and one of the four channels. Depending on the operation, the frame then ends, carries one data byte in either direction, or stays open so the host can step a wiper with every clock pulse.

Each channel has a live tap register, which sets the wiper position, and four stored register slots. Copies between the live register and a slot can act on one channel or on all four channels at once. A write into a stored slot stands in for a slow nonvolatile write. It starts a busy period of a fixed number of system clocks, and the host can see that busy flag in a status byte. The four live tap values are driven out as a flat digital bus.

Top module: `serial_quad_wiper`

## Requirements
- R1: The instruction byte and all data bytes are shifted MSB first. The input is sampled on rising serial-clock edges, and the output changes on falling edges. The instruction byte is laid out as follows: bits 7:4 hold the opcode, bits 3:2 select a stored slot, and bits 1:0 select a channel. The opcodes are 1 (slot to live), 2 (live to slot), 3 (all-channel slot to live), 4 (all-channel live to slot), 5 (status read), 6 (step mode), 9 (live read), A (live write), B (slot read) and C (slot write).
- R2: Opcode 1 copies the selected slot of the selected channel into that channel's live tap. The copy happens as soon as the eighth instruction bit is taken.
- R3: Opcode 2 copies the selected channel's live tap into its selected slot as soon as the eighth instruction bit is taken.
- R4: Opcodes 3 and 4 do the same copies for all four channels at once, each channel using its own slot at the selected slot index.
- R5: Opcode A loads the low TW bits of the data byte (the 9th to 16th bits of the frame) into the selected live tap. Opcode 9 returns that tap, zero-extended to 8 bits, MSB first. The first output bit appears on the falling edge that follows the eighth rising edge.
- R6: Opcode C writes the low TW bits of the data byte into the selected slot. Opcode B reads a slot back, zero-extended to 8 bits.
- R7: Opcode 5 returns a status byte. Bit 0 of that byte is the busy flag and the other bits are zero. The busy flag is set for NV_CYCLES system clocks after every slot write that is accepted.
- R8: While the busy flag is set, opcodes 2, 4 and C leave every slot unchanged.
- R9: After opcode 6, each further rising serial-clock edge moves the selected tap up one step if the data input is high and down one step if it is low. The tap stops at all-ones at the top and at zero at the bottom. Stepping continues until chip select goes high.
- R10: An unassigned opcode changes no register and never enables the output. The output enable is low whenever chip select is high and is set only by read opcodes.
- R11: After reset, all live taps and all slots are zero, the busy flag is clear and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. All serial lines are sampled on it. |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select. High ends a frame. |
| sck | input | 1 | Serial clock from the host, idle low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for so (high only during reads) |
| tap | output | 4*TW | Live tap of each channel, channel 0 in the low bits |

## Verification
Two things can overlap in time: a busy period that is still running and a new command that would write a stored slot. The bench provokes this by sending a slot write and then, while the busy period is still running, a status read, a second slot write and a live-to-slot copy. It then reads the slot back and expects the first value. After waiting out the busy period, a status read must return zero, and the same kind of write must then be accepted. Random command streams always wait for the busy flag to clear before a slot write, so a bench model can predict every read-back value and every tap.

// File: rtl/serial_quad_wiper.sv
module serial_quad_wiper #(
  parameter int TW        = 6,
  parameter int NV_CYCLES = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic          so_en,
  output logic [4*TW-1:0] tap
);
  localparam int BW = $clog2(NV_CYCLES + 1);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  localparam logic [3:0] OP_S2L  = 4'h1;
  localparam logic [3:0] OP_L2S  = 4'h2;
  localparam logic [3:0] OP_GS2L = 4'h3;
  localparam logic [3:0] OP_GL2S = 4'h4;
  localparam logic [3:0] OP_STAT = 4'h5;
  localparam logic [3:0] OP_STEP = 4'h6;
  localparam logic [3:0] OP_RDL  = 4'h9;
  localparam logic [3:0] OP_WRL  = 4'hA;
  localparam logic [3:0] OP_RDS  = 4'hB;
  localparam logic [3:0] OP_WRS  = 4'hC;

  logic              sck_q, stepping;
  logic [4:0]        cnt;
  logic [6:0]        sr;
  logic [7:0]        ins, osr;
  logic [BW-1:0]     busy;
  logic [3:0][TW-1:0]  live;
  logic [15:0][TW-1:0] slot;

  wire       rise = !cs_n && sck && !sck_q;
  wire       fall = !cs_n && !sck && sck_q;
  wire [7:0] nxt  = {sr, si};
  wire [3:0] op   = nxt[7:4];
  wire [1:0] rs   = nxt[3:2];
  wire [1:0] ch   = nxt[1:0];
  wire [3:0] iop  = ins[7:4];
  wire [1:0] irs  = ins[3:2];
  wire [1:0] ich  = ins[1:0];
  wire       wip  = busy != '0;

  assign tap = live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; stepping <= 1'b0; cnt <= '0; sr <= '0; ins <= '0;
      osr <= '0; busy <= '0; live <= '0; slot <= '0; so <= 1'b0; so_en <= 1'b0;
    end else begin
      sck_q <= sck;
      if (wip) busy <= busy - 1'b1;
      if (cs_n) begin
        cnt <= '0; stepping <= 1'b0; so_en <= 1'b0;
      end else begin
        if (rise) begin
          if (stepping) begin
            if (si && live[ich] != TMAX) live[ich] <= live[ich] + 1'b1;
            else if (!si && live[ich] != '0) live[ich] <= live[ich] - 1'b1;
          end else if (cnt != 5'd16) begin
            sr  <= nxt[6:0];
            cnt <= cnt + 1'b1;
            if (cnt == 5'd7) begin
              ins <= nxt;
              case (op)
                OP_S2L:  live[ch] <= slot[{ch, rs}];
                OP_L2S:  if (!wip) begin slot[{ch, rs}] <= live[ch]; busy <= BW'(NV_CYCLES); end
                OP_GS2L: for (int k = 0; k < 4; k++) live[k] <= slot[{2'(k), rs}];
                OP_GL2S: if (!wip) begin
                  for (int k = 0; k < 4; k++) slot[{2'(k), rs}] <= live[k];
                  busy <= BW'(NV_CYCLES);
                end
                OP_STEP: stepping <= 1'b1;
                OP_STAT: begin osr <= {7'b0, wip}; so_en <= 1'b1; end
                OP_RDL:  begin osr <= 8'(live[ch]); so_en <= 1'b1; end
                OP_RDS:  begin osr <= 8'(slot[{ch, rs}]); so_en <= 1'b1; end
                default: ;
              endcase
            end
            if (cnt == 5'd15) begin
              if (iop == OP_WRL) live[ich] <= nxt[TW-1:0];
              if (iop == OP_WRS && !wip) begin
                slot[{ich, irs}] <= nxt[TW-1:0];
                busy <= BW'(NV_CYCLES);
              end
            end
          end
        end
        if (fall && so_en) begin
          so  <= osr[7];
          osr <= {osr[6:0], 1'b0};
        end
      end
    end
  end

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_en);

  assert_read_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_en) |-> cnt == 5'd8);

  assert_slot_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> $stable(slot));

  assert_step_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && stepping && si && live[ich] != TMAX) |=>
      live[$past(ich)] == $past(live[ich]) + 1'b1);

  assert_step_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && stepping && !si && live[ich] == '0) |=> live[$past(ich)] == '0);
endmodule

// File: tb/sim_serial_quad_wiper.sv
module sim_serial_quad_wiper;
  localparam int TW = 6, NV = 400, H = 3;
  localparam logic [3:0] S2L = 4'h1, L2S = 4'h2, GS2L = 4'h3, GL2S = 4'h4, STAT = 4'h5,
                         STEP = 4'h6, RDL = 4'h9, WRL = 4'hA, RDS = 4'hB, WRS = 4'hC;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  wire so, so_en;
  wire [4*TW-1:0] tap;

  always #10 clk = ~clk;

  serial_quad_wiper #(.TW(TW), .NV_CYCLES(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_en(so_en), .tap(tap));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, nv_end = -1;
  bit done = 0;
  logic [TW-1:0] mw [4];
  logic [TW-1:0] md [16];

  function automatic logic [TW-1:0] stepv(logic [TW-1:0] v, bit up);
    if (up) return (v == {TW{1'b1}}) ? v : v + 1'b1;
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic int sidx(logic [1:0] ch, logic [1:0] rs);
    return {ch, rs};
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_taps(string req);
    for (int c = 0; c < 4; c++)
      check(tap[c*TW +: TW] == mw[c], req, tap[c*TW +: TW], mw[c], $sformatf("tap%0d", c));
  endtask

  task automatic frame(input logic [7:0] ins, input int tailn, input logic [63:0] tail,
                       output logic [7:0] dout, output bit oe_seen);
    dout = '0; oe_seen = 0;
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 8 + tailn; j++) begin
      si = (j < 8) ? ins[7-j] : tail[63-(j-8)];
      repeat (H) begin @(negedge clk); oe_seen |= so_en; end
      if (j >= 8 && j < 16) dout[15-j] = so;
      sck = 1;
      repeat (H) begin @(negedge clk); oe_seen |= so_en; end
      sck = 0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (cyc <= nv_end + 4) @(negedge clk);
  endtask

  task automatic cmd(input logic [3:0] op, input logic [1:0] rs, input logic [1:0] ch,
                     input logic [7:0] din, input int nsteps, input logic [63:0] steps,
                     input string req);
    logic [7:0] exp = '0, rd;
    bit isread = 0, oe, busy, accepted = 0;
    int tn = 0;
    logic [63:0] tl = '0;
    busy = cyc < nv_end;
    case (op)
      S2L:  mw[ch] = md[sidx(ch, rs)];
      L2S:  if (!busy) begin md[sidx(ch, rs)] = mw[ch]; accepted = 1; end
      GS2L: for (int k = 0; k < 4; k++) mw[k] = md[sidx(2'(k), rs)];
      GL2S: if (!busy) begin for (int k = 0; k < 4; k++) md[sidx(2'(k), rs)] = mw[k]; accepted = 1; end
      STAT: begin isread = 1; exp = {7'b0, busy}; tn = 8; end
      RDL:  begin isread = 1; exp = 8'(mw[ch]); tn = 8; end
      RDS:  begin isread = 1; exp = 8'(md[sidx(ch, rs)]); tn = 8; end
      WRL:  begin mw[ch] = din[TW-1:0]; tn = 8; tl = {din, 56'b0}; end
      WRS:  begin tn = 8; tl = {din, 56'b0};
              if (!busy) begin md[sidx(ch, rs)] = din[TW-1:0]; accepted = 1; end end
      STEP: begin tn = nsteps; tl = steps;
              for (int j = 0; j < nsteps; j++) mw[ch] = stepv(mw[ch], steps[63-j]); end
      default: tn = 8;
    endcase
    frame({op, rs, ch}, tn, tl, rd, oe);
    if (accepted) nv_end = cyc + NV;
    if (isread) check(rd == exp, req, rd, exp, $sformatf("read op %0h", op));
    check(oe == isread, "R10", oe, isread, $sformatf("output enable op %0h", op));
    check(so_en == 1'b0, "R10", so_en, 0, "enable after frame");
    check_taps(req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mw[i] = '0;
    for (int i = 0; i < 16; i++) md[i] = '0;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check_taps("R11");
    check(so_en == 1'b0, "R11", so_en, 0, "enable after reset");
    cmd(RDS, 2'd3, 2'd2, 0, 0, 0, "R11");
    cmd(STAT, 0, 0, 0, 0, 0, "R11");
    // R5 live write and read
    cmd(WRL, 0, 2'd1, 8'hEA, 0, 0, "R5");
    cmd(RDL, 0, 2'd1, 0, 0, 0, "R5");
    // R6, R7, R8 busy overlap
    cmd(WRS, 2'd2, 2'd1, 8'h15, 0, 0, "R6");
    cmd(STAT, 0, 0, 0, 0, 0, "R7");
    cmd(WRS, 2'd2, 2'd1, 8'h3F, 0, 0, "R8");
    cmd(L2S, 2'd2, 2'd1, 0, 0, 0, "R8");
    cmd(RDS, 2'd2, 2'd1, 0, 0, 0, "R8");
    wait_idle();
    cmd(STAT, 0, 0, 0, 0, 0, "R7");
    // R2 single slot to live
    cmd(S2L, 2'd2, 2'd1, 0, 0, 0, "R2");
    // R3 single live to slot
    cmd(WRL, 0, 2'd3, 8'h33, 0, 0, "R3");
    cmd(L2S, 2'd0, 2'd3, 0, 0, 0, "R3");
    wait_idle();
    cmd(RDS, 2'd0, 2'd3, 0, 0, 0, "R3");
    // R4 all-channel transfers
    for (int c = 0; c < 4; c++) begin
      wait_idle();
      cmd(WRS, 2'd1, 2'(c), 8'(8 * c + 5), 0, 0, "R4");
    end
    cmd(GS2L, 2'd1, 0, 0, 0, 0, "R4");
    for (int c = 0; c < 4; c++) cmd(WRL, 0, 2'(c), 8'(60 - 9 * c), 0, 0, "R4");
    wait_idle();
    cmd(GL2S, 2'd3, 2'd2, 0, 0, 0, "R4");
    wait_idle();
    for (int c = 0; c < 4; c++) cmd(RDS, 2'd3, 2'(c), 0, 0, 0, "R4");
    // R9 saturation at both ends
    cmd(WRL, 0, 2'd0, 8'h3D, 0, 0, "R9");
    cmd(STEP, 0, 2'd0, 0, 5, {5'b11111, 59'b0}, "R9");
    cmd(WRL, 0, 2'd0, 8'h01, 0, 0, "R9");
    cmd(STEP, 0, 2'd0, 0, 4, {4'b0000, 60'b0}, "R9");
    cmd(STEP, 0, 2'd2, 0, 6, {6'b110100, 58'b0}, "R9");
    // R10 unassigned opcodes
    cmd(4'hF, 2'd3, 2'd3, 8'hFF, 0, 0, "R10");
    cmd(4'h0, 2'd1, 2'd2, 8'h00, 0, 0, "R10");
    cmd(4'h8, 2'd2, 2'd0, 8'hAA, 0, 0, "R10");
    // R1 random mixed command stream
    for (int n = 0; n < 220; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [1:0] rs = 2'($urandom_range(0, 3));
      logic [1:0] ch = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      logic [63:0] st = {$urandom, $urandom};
      if (op == L2S || op == GL2S || op == WRS || op == STAT) wait_idle();
      cmd(op, rs, ch, d, $urandom_range(1, 20), st, "R1");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 180000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule